// File: doc/BRIEF.md
# Armable Edge/Level Interrupt Controller

This block takes a bitmap of asynchronous interrupt inputs and turns each one into a request latched for a host. Each line first passes through a two-flop synchroniser. A glitch filter then accepts a new value only after it has stayed the same for a set number of clock cycles; the default is 375 cycles, which is 1.5 µs at 250 MHz. Each line can be set to edge or level sensing, and to active-high or active-low polarity.

There are two gates per line. The arm bit decides whether a detected condition is latched as a request at all. The enable bit decides whether a latched request is passed on to the host. When a request is passed on, the single host interrupt output pulses for one cycle and the line's pending bit is set. While the pending bit stays set, that line cannot raise the output again. The host clears a line's request and pending bits together by writing ones to a clear register.

The host reaches all of this through a small 32-bit register port with read and write strobes. Every control and status register is a bitmap with one bit per line.

Top module: `irq_gate_ctrl`

## Requirements
- R1: In the sense-mode register (word address 2), a line bit of 1 makes the line level-sensitive. A bit of 0 makes it edge-triggered.
- R2: In the polarity register (word address 3), a line bit of 1 selects a rising edge or a high level. A bit of 0 selects a falling edge or a low level.
- R3: After reset every register reads zero, so every line starts disarmed. A line whose arm bit (word address 1) is 0 never latches a request, whatever its input does.
- R4: An armed line whose condition occurs sets its request bit (readable at word address 4). The host output stays low for that line while its enable bit (word address 0) is 0.
- R5: A line whose request and enable bits are both 1 and whose pending bit is 0 drives `irq_o` high for exactly one cycle. It then sets its pending bit (readable at word address 5). While the pending bit is 1, that line drives no further pulse.
- R6: A filtered input takes a new value only after the synchronised input has held that value for QUAL_CYCLES consecutive cycles. A shorter pulse causes no request.
- R7: Writing to the clear register (word address 6) clears the request and pending bits of every line whose data bit is 1. Bits written as 0 leave their lines unchanged. If a condition occurs on a line in the same cycle as its clear, the new request is kept.
- R8: Word addresses 0 to 3 are read/write. A read returns data on `rdata` one cycle after `rd_en`, and bits at and above LINES read as zero.
- R9: `irq_o` is the OR over all lines of the one-cycle delivery condition. Lines that become ready in the same cycle produce one shared pulse and set all their pending bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_in | input | LINES | Asynchronous interrupt inputs |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| irq_o | output | 1 | Combined host interrupt pulse |

## Verification
A wrong arm, mode or polarity bit appears as a wrong request bit. It can be read back within QUAL_CYCLES plus about four cycles after an input changes. A pending bit stuck at 0 shows as extra pulses on `irq_o` when the line fires again. A pending bit stuck at 1 shows as a pulse that never arrives. A filter counter that is too short lets a pulse shorter than QUAL_CYCLES latch a request. A clear that is wrong shows on the next read of the request or pending register.

// File: rtl/irq_gate_ctrl.sv
module irq_gate_ctrl #(
  parameter int LINES       = 8,
  parameter int QUAL_CYCLES = 375
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] irq_in,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [2:0]       addr,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  output logic             irq_o
);
  localparam int CW = $clog2(QUAL_CYCLES + 1);
  localparam logic [2:0] A_EN = 3'd0, A_ARM = 3'd1, A_LVL = 3'd2, A_POL = 3'd3,
                         A_REQ = 3'd4, A_PND = 3'd5, A_CLR = 3'd6;

  logic [LINES-1:0] s1, s2, filt, filt_d;
  logic [LINES-1:0] en_q, arm_q, lvl_q, pol_q, req_q, pnd_q;
  logic [LINES-1:0] rise, fall, hit, clr, deliver;
  logic [CW-1:0]    cnt [LINES];

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= '0;
      s2 <= '0;
      filt_d <= '0;
    end else begin
      s1 <= irq_in;
      s2 <= s1;
      filt_d <= filt;
    end
  end

  for (genvar i = 0; i < LINES; i++) begin : g_qual
    always_ff @(posedge clk) begin
      if (rst) begin
        cnt[i]  <= '0;
        filt[i] <= 1'b0;
      end else if (s2[i] != filt[i]) begin
        if (cnt[i] == CW'(QUAL_CYCLES - 1)) begin
          filt[i] <= s2[i];
          cnt[i]  <= '0;
        end else begin
          cnt[i] <= cnt[i] + 1'b1;
        end
      end else begin
        cnt[i] <= '0;
      end
    end
  end

  assign rise    = filt & ~filt_d;
  assign fall    = ~filt & filt_d;
  assign hit     = (lvl_q & ~(filt ^ pol_q)) | (~lvl_q & pol_q & rise) | (~lvl_q & ~pol_q & fall);
  assign clr     = (wr_en && addr == A_CLR) ? wdata[LINES-1:0] : '0;
  assign deliver = req_q & en_q & ~pnd_q;
  assign irq_o   = |deliver;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      arm_q <= '0;
      lvl_q <= '0;
      pol_q <= '0;
      req_q <= '0;
      pnd_q <= '0;
    end else begin
      req_q <= (req_q & ~clr) | (hit & arm_q);
      pnd_q <= (pnd_q | deliver) & ~clr;
      if (wr_en) begin
        case (addr)
          A_EN:    en_q  <= wdata[LINES-1:0];
          A_ARM:   arm_q <= wdata[LINES-1:0];
          A_LVL:   lvl_q <= wdata[LINES-1:0];
          A_POL:   pol_q <= wdata[LINES-1:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      case (addr)
        A_EN:    rdata <= 32'(en_q);
        A_ARM:   rdata <= 32'(arm_q);
        A_LVL:   rdata <= 32'(lvl_q);
        A_POL:   rdata <= 32'(pol_q);
        A_REQ:   rdata <= 32'(req_q);
        A_PND:   rdata <= 32'(pnd_q);
        default: rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_gate_ctrl_chk.sv
module irq_gate_ctrl_chk #(
  parameter int LINES = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [2:0]       addr,
  input logic [31:0]      wdata,
  input logic [LINES-1:0] arm,
  input logic [LINES-1:0] en,
  input logic [LINES-1:0] req,
  input logic [LINES-1:0] pnd,
  input logic             irq
);
  a_r3_disarmed_no_latch: assert property (@(posedge clk) disable iff (rst)
    ((req & ~$past(req) & ~$past(arm)) == '0));

  a_r4_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
    irq |-> ((req & en) != '0));

  a_r5_pending_follows_delivery: assert property (@(posedge clk) disable iff (rst)
    ((pnd & ~$past(pnd) & ~$past(req & en)) == '0));

  a_r7_clear_drops_pending: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 3'd6) |=> ((pnd & $past(wdata[LINES-1:0])) == '0));
endmodule

bind irq_gate_ctrl irq_gate_ctrl_chk #(.LINES(LINES)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .arm(arm_q), .en(en_q), .req(req_q), .pnd(pnd_q), .irq(irq_o)
);

// File: tb/irq_gate_ctrl_test.sv
module irq_gate_ctrl_test;
  localparam int LINES = 8;
  localparam int QUAL  = 6;
  localparam int SETTLE = QUAL + 10;
  localparam logic [2:0] A_EN = 3'd0, A_ARM = 3'd1, A_LVL = 3'd2, A_POL = 3'd3,
                         A_REQ = 3'd4, A_PND = 3'd5, A_CLR = 3'd6;
  // {level, polarity, start value, end value, expected request}
  localparam logic [4:0] VEC [8] = '{
    5'b0_1_0_1_1, 5'b0_1_1_0_0, 5'b0_0_1_0_1, 5'b0_0_0_1_0,
    5'b1_1_1_1_1, 5'b1_1_0_0_0, 5'b1_0_0_0_1, 5'b1_0_1_1_0
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [LINES-1:0] irq_in = '0;
  logic             wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]       addr = '0;
  logic [31:0]      wdata = '0;
  logic [31:0]      rdata;
  logic             irq_o;

  int total = 0, bad = 0, pulses = 0, cycles = 0, base = 0;
  logic [31:0] d;

  irq_gate_ctrl #(.LINES(LINES), .QUAL_CYCLES(QUAL)) uut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
  );

  always #2 clk = ~clk;

  always @(negedge clk) begin
    if (!rst && irq_o) pulses++;
    cycles++;
    if (cycles > 100000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] v);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = v;
    @(negedge clk); wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; v = rdata;
  endtask

  task automatic settle();
    repeat (SETTLE) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; irq_in = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    do_reset();
    // R3: reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      chk("R3 reset register zero", d, 32'h0);
    end
    chk("R3 irq low after reset", 32'(irq_o), 32'h0);

    // R1 R2: table of mode/polarity vectors on line 0
    foreach (VEC[k]) begin
      wr(A_ARM, 32'h0);
      wr(A_LVL, {31'h0, VEC[k][4]});
      wr(A_POL, {31'h0, VEC[k][3]});
      wr(A_EN, 32'h1);
      irq_in[0] = VEC[k][2];
      settle();
      wr(A_CLR, 32'hFF);
      wr(A_ARM, 32'h1);
      irq_in[0] = VEC[k][1];
      settle();
      rd(A_REQ, d);
      chk($sformatf("R1 R2 vector %0d request", k), d, {31'h0, VEC[k][0]});
      rd(A_PND, d);
      chk($sformatf("R5 vector %0d pending", k), d, {31'h0, VEC[k][0]});
    end

    do_reset();
    // R3: disarmed line ignores a rising edge
    wr(A_EN, 32'hFF); wr(A_POL, 32'hFF);
    base = pulses;
    irq_in[1] = 1'b1; settle();
    rd(A_REQ, d);
    chk("R3 disarmed request", d, 32'h0);
    chk("R3 disarmed pulses", 32'(pulses - base), 32'h0);

    // R4: armed, not enabled
    irq_in[1] = 1'b0; wr(A_EN, 32'h0); wr(A_ARM, 32'h2); settle();
    wr(A_CLR, 32'hFF);
    base = pulses;
    irq_in[1] = 1'b1; settle();
    rd(A_REQ, d);
    chk("R4 armed request latched", d, 32'h2);
    chk("R4 no pulse while disabled", 32'(pulses - base), 32'h0);
    rd(A_PND, d);
    chk("R4 pending stays clear", d, 32'h0);

    // R5: enable delivers one pulse and sets pending
    wr(A_EN, 32'h2); settle();
    chk("R5 single pulse", 32'(pulses - base), 32'h1);
    rd(A_PND, d);
    chk("R5 pending set", d, 32'h2);

    // R5: pending blocks another delivery
    irq_in[1] = 1'b0; settle();
    irq_in[1] = 1'b1; settle();
    chk("R5 blocked while pending", 32'(pulses - base), 32'h1);

    // R7: zeros leave bits alone, ones clear them
    wr(A_CLR, 32'h0);
    rd(A_REQ, d);
    chk("R7 zero write keeps request", d, 32'h2);
    rd(A_PND, d);
    chk("R7 zero write keeps pending", d, 32'h2);
    wr(A_CLR, 32'h2);
    rd(A_REQ, d);
    chk("R7 clear request", d, 32'h0);
    rd(A_PND, d);
    chk("R7 clear pending", d, 32'h0);
    irq_in[1] = 1'b0; settle();
    irq_in[1] = 1'b1; settle();
    chk("R5 delivers again after clear", 32'(pulses - base), 32'h2);

    // R6: glitch rejection then a qualified pulse on line 2
    wr(A_ARM, 32'h4); wr(A_EN, 32'h4); wr(A_CLR, 32'hFF);
    irq_in[2] = 1'b1; repeat (3) @(negedge clk); irq_in[2] = 1'b0;
    settle();
    rd(A_REQ, d);
    chk("R6 short pulse rejected", d, 32'h0);
    irq_in[2] = 1'b1; repeat (12) @(negedge clk); irq_in[2] = 1'b0;
    settle();
    rd(A_REQ, d);
    chk("R6 long pulse accepted", d, 32'h4);

    // R8: read back and unused bits
    wr(A_LVL, 32'hFFFF_FFA5);
    rd(A_LVL, d);
    chk("R8 level readback", d, 32'hA5);
    wr(A_LVL, 32'h0);

    // R9: two lines ready together share one pulse
    wr(A_CLR, 32'hFF); wr(A_EN, 32'h0); wr(A_ARM, 32'h28); settle();
    irq_in[3] = 1'b1; irq_in[5] = 1'b1; settle();
    base = pulses;
    wr(A_EN, 32'h28); settle();
    chk("R9 one shared pulse", 32'(pulses - base), 32'h1);
    rd(A_PND, d);
    chk("R9 both pending", d, 32'h28);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule